// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Resolver

This block is the arbitration heart of an eight-line interrupt controller. Request lines arrive already conditioned (edge or level detection happens upstream). They are captured each cycle into a pending register, filtered by a mask register and compared against the set of inputs currently being serviced. When an unmasked pending input outranks everything in service, the block raises its interrupt output towards the processor.

The processor answers with two acknowledge strobes. On the first strobe the block picks the winner and marks it in service. On the second strobe it presents one vector byte, made of a programmed five-bit base and the three-bit index of the winner. Service ends with a command that retires either the highest in-service input or a named one. Service can also end by itself on the second strobe when automatic retirement is enabled. With rotation enabled, an input that has just been retired drops to the lowest priority. A small command port programs the base, the mask and the modes, and chooses which of the three registers appears on the read port.

Top module: `irq_arbiter_core`

## Requirements
- R1: After synchronous reset, int_o and vec_oe_o are low and the read port shows the pending view with value 0. The pending, in-service and mask registers are all zero, the base is zero and both modes are off.
- R2: With rotation off, input 0 ranks highest and input 7 lowest. The vector byte is the base in bits 7..3 and the winning index in bits 2..0. Command op 1 loads the base from cmd_data_i[7:3].
- R3: A masked input (op 2 writes the mask from cmd_data_i, where 1 means masked) never raises int_o and never wins an acknowledge.
- R4: int_o is high only while no acknowledge is in progress and some unmasked pending input ranks strictly above every in-service input.
- R5: On the first ack_i strobe the winner's in-service bit is set. On the second strobe, vec_oe_o is high in that same cycle and vec_o carries the vector.
- R6: If no input qualifies at the first strobe, the second strobe returns the base with index 7, and no in-service bit is set.
- R7: Op 4 (non-specific retire) clears the highest-ranked set in-service bit.
- R8: Op 5 (specific retire) clears the in-service bit named by cmd_data_i[2:0].
- R9: With automatic retirement on (op 3, cmd_data_i[0]=1), the granted in-service bit clears at the second strobe.
- R10: With rotation on (op 3, cmd_data_i[1]=1), a retired input becomes the lowest priority, so the input above it ranks highest.
- R11: Op 6 selects the read view from cmd_data_i[1:0]. The value 2'b10 selects pending requests, 2'b11 selects in-service bits, and 2'b0x selects the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Conditioned request lines |
| ack_i | input | 1 | Acknowledge strobe, one cycle per pulse |
| cmd_op_i | input | 3 | Command opcode (0 = none) |
| cmd_data_i | input | 8 | Command operand |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte, valid while vec_oe_o is high |
| vec_oe_o | output | 1 | Vector drive enable (second strobe) |
| rd_data_o | output | 8 | Selected register view |

## Verification
The fixed-order picker is swept over all 256 request patterns with nothing masked, which separates a correct lowest-index pick from any off-by-one or reversed ordering. The empty pattern exercises the spurious path. A second sweep covers all 256 masks with every input requesting, which separates the masking of a winner from the masking of the interrupt line. A rotation sweep retires each input in turn and checks that its upper neighbour wins next. Directed nesting cases separate strict from non-strict comparison against the in-service set, and show which bit each retire style clears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_IN = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - IDX_W;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_BASE   = 3'd1,
        OP_MASK   = 3'd2,
        OP_MODE   = 3'd3,
        OP_EOI_NS = 3'd4,
        OP_EOI_SP = 3'd5,
        OP_RDSEL  = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        VIEW_IMR = 2'd0,
        VIEW_IRR = 2'd1,
        VIEW_ISR = 2'd2
    } view_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic aeoi;
        logic rotate;
    } mode_t;

    function automatic view_e decode_view(input logic [1:0] f);
        if (!f[1])     return VIEW_IMR;
        else if (f[0]) return VIEW_ISR;
        else           return VIEW_IRR;
    endfunction

endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] low_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [IW:0]   rank_o
);
    // rank 0 sits just above the lowest-priority position low_i
    logic [IW-1:0] pos;

    always_comb begin
        any_o  = 1'b0;
        idx_o  = low_i;
        rank_o = (IW+1)'(N);
        pos    = '0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = low_i + IW'(k + 1);
            if (vec_i[pos]) begin
                any_o  = 1'b1;
                idx_o  = pos;
                rank_o = (IW+1)'(k);
            end
        end
    end
endmodule

// File: rtl/irqc_ack_seq.sv
module irqc_ack_seq
    import irqc_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ack_i,
    input  logic          grant_ok_i,
    input  logic [IW-1:0] grant_idx_i,
    output logic          first_o,
    output logic          second_o,
    output logic          busy_o,
    output logic          spur_o,
    output logic [IW-1:0] sel_o
);
    phase_e        phase_q;
    logic          spur_q;
    logic [IW-1:0] sel_q;

    assign first_o  = ack_i && (phase_q == PH_IDLE);
    assign second_o = ack_i && (phase_q == PH_SECOND);
    assign busy_o   = (phase_q == PH_SECOND);
    assign spur_o   = spur_q;
    assign sel_o    = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            spur_q  <= 1'b0;
            sel_q   <= '0;
        end else if (first_o) begin
            phase_q <= PH_SECOND;
            spur_q  <= !grant_ok_i;
            sel_q   <= grant_ok_i ? grant_idx_i : '1;
        end else if (second_o) begin
            phase_q <= PH_IDLE;
        end
    end
endmodule

// File: rtl/irqc_cmd_regs.sv
module irqc_cmd_regs
    import irqc_pkg::*;
#(
    parameter int N  = NUM_IN,
    parameter int BW = BASE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_i,
    input  logic [7:0]    data_i,
    output logic [BW-1:0] base_o,
    output logic [N-1:0]  imr_o,
    output mode_t         mode_o,
    output view_e         view_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_o <= '0;
            imr_o  <= '0;
            mode_o <= '0;
            view_o <= VIEW_IRR;
        end else begin
            unique case (op_e'(op_i))
                OP_BASE:  base_o <= data_i[7 -: BW];
                OP_MASK:  imr_o  <= data_i[N-1:0];
                OP_MODE: begin
                    mode_o.aeoi   <= data_i[0];
                    mode_o.rotate <= data_i[1];
                end
                OP_RDSEL: view_o <= decode_view(data_i[1:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_arbiter_core.sv
module irq_arbiter_core
    import irqc_pkg::*;
#(
    parameter int N  = NUM_IN,
    parameter int IW = IDX_W,
    parameter int BW = BASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic         ack_i,
    input  logic [2:0]   cmd_op_i,
    input  logic [7:0]   cmd_data_i,
    output logic         int_o,
    output logic [7:0]   vec_o,
    output logic         vec_oe_o,
    output logic [7:0]   rd_data_o
);
    logic [N-1:0]  irr_q, isr_q, imr_q, pend;
    logic [IW-1:0] low_q;
    logic [BW-1:0] base_q;
    mode_t         mode_q;
    view_e         view_q;

    logic          req_any, isr_any;
    logic [IW-1:0] req_idx, isr_idx;
    logic [IW:0]   req_rank, isr_rank;
    logic          grant_ok;

    logic          first, second, busy, spur;
    logic [IW-1:0] sel;

    logic [N-1:0]  set_v, clr_v;
    logic          rot_en;
    logic [IW-1:0] rot_idx;

    irqc_cmd_regs #(.N(N), .BW(BW)) u_regs (
        .clk(clk), .rst(rst), .op_i(cmd_op_i), .data_i(cmd_data_i),
        .base_o(base_q), .imr_o(imr_q), .mode_o(mode_q), .view_o(view_q)
    );

    assign pend = irr_q & ~imr_q;

    irqc_prio_pick #(.N(N), .IW(IW)) u_pick_req (
        .vec_i(pend), .low_i(low_q),
        .any_o(req_any), .idx_o(req_idx), .rank_o(req_rank)
    );

    irqc_prio_pick #(.N(N), .IW(IW)) u_pick_isr (
        .vec_i(isr_q), .low_i(low_q),
        .any_o(isr_any), .idx_o(isr_idx), .rank_o(isr_rank)
    );

    assign grant_ok = req_any && (req_rank < isr_rank);

    irqc_ack_seq #(.IW(IW)) u_ack (
        .clk(clk), .rst(rst), .ack_i(ack_i),
        .grant_ok_i(grant_ok), .grant_idx_i(req_idx),
        .first_o(first), .second_o(second), .busy_o(busy),
        .spur_o(spur), .sel_o(sel)
    );

    // in-service set and clear requests for this cycle
    always_comb begin
        set_v   = '0;
        clr_v   = '0;
        rot_en  = 1'b0;
        rot_idx = low_q;
        if (first && grant_ok)
            set_v[req_idx] = 1'b1;
        if (op_e'(cmd_op_i) == OP_EOI_NS && isr_any) begin
            clr_v[isr_idx] = 1'b1;
            rot_en         = 1'b1;
            rot_idx        = isr_idx;
        end else if (op_e'(cmd_op_i) == OP_EOI_SP) begin
            clr_v[cmd_data_i[IW-1:0]] = 1'b1;
            rot_en                    = 1'b1;
            rot_idx                   = cmd_data_i[IW-1:0];
        end
        if (second && mode_q.aeoi && !spur) begin
            clr_v[sel] = 1'b1;
            rot_en     = 1'b1;
            rot_idx    = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
            isr_q <= '0;
            low_q <= '1;
        end else begin
            irr_q <= req_i;
            isr_q <= (isr_q & ~clr_v) | set_v;
            if (!mode_q.rotate)
                low_q <= '1;
            else if (rot_en)
                low_q <= rot_idx;
        end
    end

    assign int_o    = grant_ok && !busy;
    assign vec_oe_o = second;
    assign vec_o    = second ? {base_q, sel} : '0;

    always_comb begin
        unique case (view_q)
            VIEW_IMR: rd_data_o = 8'(imr_q);
            VIEW_ISR: rd_data_o = 8'(isr_q);
            default:  rd_data_o = 8'(irr_q);
        endcase
    end
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks
    import irqc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       int_o,
    input logic       vec_oe_o,
    input logic       ack_i,
    input logic [2:0] cmd_op_i,
    input logic [7:0] irr_q,
    input logic [7:0] imr_q,
    input logic [7:0] isr_q,
    input logic       busy,
    input logic       spur,
    input mode_t      mode_q
);
    // R3: the interrupt line needs an unmasked pending input behind it
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        int_o |-> ((irr_q & ~imr_q) != 8'h00));

    // R5: one acknowledge adds at most one in-service bit
    a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(isr_q & ~$past(isr_q)));

    // R6: a first strobe with nothing qualifying leaves in-service untouched
    a_r6_spurious_no_isr: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !busy && !int_o && cmd_op_i == 3'd0) |=> (isr_q == $past(isr_q)));

    // R9: automatic retirement removes a bit on the second strobe
    a_r9_auto_retire: assert property (@(posedge clk) disable iff (rst)
        (vec_oe_o && mode_q.aeoi && !spur && cmd_op_i == 3'd0)
        |=> ($countones(isr_q) < $countones($past(isr_q))));

    // R4: no new request is raised while the vector cycle is pending
    a_r4_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !int_o);
endmodule

bind irq_arbiter_core irqc_checks u_chk (
    .clk(clk), .rst(rst), .int_o(int_o), .vec_oe_o(vec_oe_o),
    .ack_i(ack_i), .cmd_op_i(cmd_op_i), .irr_q(irr_q), .imr_q(imr_q),
    .isr_q(isr_q), .busy(busy), .spur(spur), .mode_q(mode_q)
);

// File: tb/irq_arbiter_core_test.sv
`timescale 1ns/1ps
module irq_arbiter_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       ack_i = 1'b0;
    logic [2:0] cmd_op_i = '0;
    logic [7:0] cmd_data_i = '0;
    logic       int_o, vec_oe_o;
    logic [7:0] vec_o, rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_arbiter_core uut (
        .clk(clk), .rst(rst), .req_i(req_i), .ack_i(ack_i),
        .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i),
        .int_o(int_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o),
        .rd_data_o(rd_data_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        cmd_op_i = op; cmd_data_i = d;
        @(negedge clk);
        cmd_op_i = 3'd0; cmd_data_i = '0;
    endtask

    task automatic set_req(input logic [7:0] v);
        @(negedge clk);
        req_i = v;
        @(negedge clk);
    endtask

    task automatic ack_pair(output logic [7:0] v, output logic oe);
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        #1;
        v = vec_o; oe = vec_oe_o;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    function automatic logic [2:0] lowest_one(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) lowest_one = 3'(i);
        if (v == 0) lowest_one = 3'd7;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 int_o", {7'd0, int_o}, 8'h00);
        chk("R1 vec_oe", {7'd0, vec_oe_o}, 8'h00);
        chk("R1 rd view", rd_data_o, 8'h00);

        cmd(3'd1, 8'h40);       // base 8
        cmd(3'd6, 8'h03);       // view in-service

        // R2/R5/R6/R7 fixed-order sweep over every request pattern
        for (int p = 0; p < 256; p++) begin
            set_req(8'(p));
            chk("R2 int_o", {7'd0, int_o}, {7'd0, p != 0});
            ack_pair(v, oe);
            chk("R5 vec_oe", {7'd0, oe}, 8'h01);
            if (p == 0) begin
                chk("R6 spurious vector", v, 8'h47);
                chk("R6 no isr", rd_data_o, 8'h00);
            end else begin
                chk("R2 vector", v, {5'd8, lowest_one(8'(p))});
                chk("R5 isr bit", rd_data_o, 8'h01 << lowest_one(8'(p)));
            end
            set_req(8'h00);
            cmd(3'd4, 8'h00);
            chk("R7 retired", rd_data_o, 8'h00);
        end

        // R3 mask sweep with all inputs requesting
        for (int m = 0; m < 256; m++) begin
            cmd(3'd2, 8'(m));
            set_req(8'hFF);
            chk("R3 int_o", {7'd0, int_o}, {7'd0, m != 255});
            ack_pair(v, oe);
            chk("R3 winner", v, {5'd8, lowest_one(~8'(m))});
            set_req(8'h00);
            cmd(3'd4, 8'h00);
        end
        cmd(3'd2, 8'h00);

        // R4 nesting, R7 and R8 retire styles
        set_req(8'h08);
        ack_pair(v, oe);
        set_req(8'h20);
        chk("R4 lower blocked", {7'd0, int_o}, 8'h00);
        set_req(8'h28);
        chk("R4 equal blocked", {7'd0, int_o}, 8'h00);
        set_req(8'h22);
        chk("R4 higher raises", {7'd0, int_o}, 8'h01);
        ack_pair(v, oe);
        chk("R4 nested vector", v, 8'h41);
        chk("R5 nested isr", rd_data_o, 8'h0A);
        set_req(8'h00);
        cmd(3'd5, 8'h03);
        chk("R8 specific clear", rd_data_o, 8'h02);
        cmd(3'd4, 8'h00);
        chk("R7 nonspecific clear", rd_data_o, 8'h00);

        // R9 automatic retirement
        cmd(3'd3, 8'h01);
        set_req(8'h10);
        ack_pair(v, oe);
        chk("R9 vector", v, 8'h44);
        chk("R9 auto cleared", rd_data_o, 8'h00);
        set_req(8'h00);

        // R10 rotation sweep
        cmd(3'd3, 8'h02);
        cmd(3'd1, 8'hA8);
        for (int n = 0; n < 8; n++) begin
            set_req(8'h01 << n);
            ack_pair(v, oe);
            set_req(8'h00);
            cmd(3'd4, 8'h00);
            set_req(8'hFF);
            ack_pair(v, oe);
            chk("R10 rotated winner", v, {5'd21, 3'((n + 1) % 8)});
            set_req(8'h00);
            cmd(3'd4, 8'h00);
            chk("R10 retired", rd_data_o, 8'h00);
        end
        cmd(3'd3, 8'h00);

        // R11 read view selection
        cmd(3'd2, 8'hA5);
        cmd(3'd6, 8'h00);
        chk("R11 mask view", rd_data_o, 8'hA5);
        set_req(8'h5A);
        cmd(3'd6, 8'h02);
        chk("R11 pending view", rd_data_o, 8'h5A);
        cmd(3'd6, 8'h01);
        chk("R11 mask view alt", rd_data_o, 8'hA5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule